// File: doc/BRIEF.md
# Timestamp-Scheduled Pin Event Generator

This block drives a single output pin from a stream of timed events. Each event word carries a due time and the logic level the pin must take at that time. A free-running reference counter advances once per clock. The block compares the time of the event at the head of the stream with the counter. When that time is reached, the block takes the event and moves the pin to the requested level.

Each instance serves one pin from its own event stream. It is the opposite of edge timestamping: instead of recording when a pin changed, it makes the pin change at times given in advance. Events reach the block over a plain valid/ready stream. Times are compared modulo the counter range, so schedules stay correct when the counter wraps.

The block reports two conditions. A sticky late flag shows that an event was already overdue when it first reached the head of the stream. An empty flag shows that no event is being offered.

Top module: `ts_pin_scheduler`

## Requirements
- R1: An event word is TIME_W+1 bits wide. Bit TIME_W (bit 31 by default) is the pin level to apply, and bits TIME_W-1:0 (30:0 by default) are the due time.
- R2: While reset is held and in the first cycle after it, `pin_o` equals the parameter RESET_LEVEL, `late_o` is 0 and `ref_time_o` is 0.
- R3: `ref_time_o` increases by exactly one every clock cycle and wraps from its all-ones value to 0.
- R4: When a valid head event's due time equals `ref_time_o`, `evt_ready_o` is 1 in that cycle. `pin_o` shows the event's level from the next cycle on.
- R5: While the head event's due time lies in the future, `evt_ready_o` is 0 and `pin_o` holds its level.
- R6: The wait is measured as (due time − `ref_time_o`) modulo 2^TIME_W. The event is due when this difference is zero or its top bit is set. A due time just past the counter wrap is therefore still waited for.
- R7: An event that is already overdue in the first cycle it is offered is taken in that same cycle, and it sets `late_o`. `late_o` then stays 1 until reset.
- R8: At most one event is taken per cycle. Events that share a due time are applied on consecutive cycles in arrival order. An event whose time equals that of the event just applied does not set `late_o`.
- R9: With no event offered, `empty_o` is 1, `evt_ready_o` is 0 and `pin_o` keeps its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_valid_i | input | 1 | Head event is offered |
| evt_data_i | input | TIME_W+1 | Event word: level in the top bit, due time below it |
| evt_ready_o | output | 1 | Head event is taken this cycle |
| pin_o | output | 1 | Generated pin level |
| late_o | output | 1 | Sticky overdue-event flag |
| empty_o | output | 1 | No event is being offered |
| ref_time_o | output | TIME_W | Reference timestamp counter |

## Verification
On every cycle, the assertions check these rules:
- the counter steps by one;
- the pin changes only when an event is taken, and then to that event's level;
- an event whose time equals the counter is always taken;
- the late flag never falls.

Other behaviour can only be shown by the bench's scenarios: the exact cycle the pin moves, the wrap-aware wait across the counter rollover, late detection of an overdue arrival against a same-time follower, and ordering of events that share a time. A second, narrow-counter instance makes the wrap reachable in a short run.

// File: rtl/ts_pkg.sv
package ts_pkg;

    parameter int unsigned TS_DEFAULT_W = 31;

    typedef enum logic [1:0] {
        CMP_FUTURE = 2'd0,
        CMP_NOW    = 2'd1,
        CMP_PAST   = 2'd2
    } cmp_e;

endpackage

// File: rtl/ts_ref_counter.sv
module ts_ref_counter #(
    parameter int unsigned W = ts_pkg::TS_DEFAULT_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R3
    ref_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> cnt_q == ($past(cnt_q) + ONE));

endmodule

// File: rtl/ts_due_compare.sv
module ts_due_compare #(
    parameter int unsigned W = ts_pkg::TS_DEFAULT_W
) (
    input  logic [W-1:0] due_i,
    input  logic [W-1:0] now_i,
    output ts_pkg::cmp_e cmp_o
);

    logic [W-1:0] gap;

    always_comb begin
        gap = due_i - now_i;
        if (gap == '0)        cmp_o = ts_pkg::CMP_NOW;
        else if (gap[W-1])    cmp_o = ts_pkg::CMP_PAST;
        else                  cmp_o = ts_pkg::CMP_FUTURE;
    end

endmodule

// File: rtl/ts_pin_scheduler.sv
module ts_pin_scheduler #(
    parameter int unsigned TIME_W      = ts_pkg::TS_DEFAULT_W,
    parameter bit          RESET_LEVEL = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              evt_valid_i,
    input  logic [TIME_W:0]   evt_data_i,
    output logic              evt_ready_o,
    output logic              pin_o,
    output logic              late_o,
    output logic              empty_o,
    output logic [TIME_W-1:0] ref_time_o
);

    localparam int unsigned LVL_BIT = TIME_W;

    typedef struct packed {
        logic              pin;
        logic              late;
        logic              seen;
        logic              have_last;
        logic [TIME_W-1:0] last_ts;
    } sched_t;

    sched_t            st_d, st_q;
    logic [TIME_W-1:0] now_w;
    logic [TIME_W-1:0] head_ts;
    logic              head_lvl;
    ts_pkg::cmp_e      cmp_w;
    logic              pop;
    logic              first_look;
    logic              follower;

    ts_ref_counter #(.W(TIME_W)) ref_cnt_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .cnt_o (now_w)
    );

    assign head_ts  = evt_data_i[TIME_W-1:0];
    assign head_lvl = evt_data_i[LVL_BIT];

    ts_due_compare #(.W(TIME_W)) due_cmp_i (
        .due_i(head_ts),
        .now_i(now_w),
        .cmp_o(cmp_w)
    );

    always_comb begin
        st_d       = st_q;
        pop        = evt_valid_i && (cmp_w != ts_pkg::CMP_FUTURE);
        first_look = evt_valid_i && !st_q.seen;
        follower   = st_q.have_last && (head_ts == st_q.last_ts);
        if (first_look && (cmp_w == ts_pkg::CMP_PAST) && !follower) begin
            st_d.late = 1'b1;
        end
        if (pop) begin
            st_d.pin       = head_lvl;
            st_d.seen      = 1'b0;
            st_d.have_last = 1'b1;
            st_d.last_ts   = head_ts;
        end else if (evt_valid_i) begin
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.pin       <= RESET_LEVEL;
            st_q.late      <= 1'b0;
            st_q.seen      <= 1'b0;
            st_q.have_last <= 1'b0;
            st_q.last_ts   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_ready_o = pop;
    assign pin_o       = st_q.pin;
    assign late_o      = st_q.late;
    assign empty_o     = !evt_valid_i;
    assign ref_time_o  = now_w;

    // R5
    pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !evt_ready_o |=> $stable(pin_o));

    // R4
    pin_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_ready_o |=> pin_o == $past(evt_data_i[LVL_BIT]));

    // R4
    due_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_valid_i && (now_w == evt_data_i[TIME_W-1:0])) |-> evt_ready_o);

    // R7
    late_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        late_o |=> late_o);

    // R9
    idle_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty_o |-> !evt_ready_o);

endmodule

// File: tb/ts_pin_scheduler_tb.sv
module ts_pin_scheduler_tb_top;

    localparam int unsigned TW  = 31;
    localparam int unsigned TWN = 8;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    always #5 clk = ~clk;

    logic          v_i = 1'b0;
    logic [TW:0]   d_i = '0;
    logic          rdy, pin, late, empty;
    logic [TW-1:0] now;

    logic           vn_i = 1'b0;
    logic [TWN:0]   dn_i = '0;
    logic           rdy_n, pin_n, late_n, empty_n;
    logic [TWN-1:0] now_n;

    ts_pin_scheduler #(.TIME_W(TW), .RESET_LEVEL(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .evt_valid_i(v_i), .evt_data_i(d_i),
        .evt_ready_o(rdy), .pin_o(pin), .late_o(late), .empty_o(empty),
        .ref_time_o(now));

    ts_pin_scheduler #(.TIME_W(TWN), .RESET_LEVEL(1'b0)) dut_w_i (
        .clk_i(clk), .rst_ni(rst_ni), .evt_valid_i(vn_i), .evt_data_i(dn_i),
        .evt_ready_o(rdy_n), .pin_o(pin_n), .late_o(late_n), .empty_o(empty_n),
        .ref_time_o(now_n));

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [TW:0] mk(input logic lvl, input logic [TW-1:0] t);
        return {lvl, t};
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check(pin == 1'b1, "R2", "pin in reset", 32'(pin), 1);
        rst_ni = 1'b1;
        #1;
        check(now == '0, "R2", "ref after reset", 32'(now), 0);
        check(pin == 1'b1, "R2", "pin after reset", 32'(pin), 1);
        check(late == 1'b0, "R2", "late after reset", 32'(late), 0);
        check(empty == 1'b1 && rdy == 1'b0, "R9", "empty idle", {30'd0, empty, rdy}, 2);
    endtask

    task automatic t_step();
        logic [TW-1:0] r0;
        @(negedge clk);
        r0 = now;
        @(negedge clk);
        check(now == r0 + 1, "R3", "ref step", 32'(now), 32'(r0 + 1));
    endtask

    task automatic t_future();
        logic [TW-1:0] t;
        bit held = 1'b1;
        @(negedge clk);
        t = now + 20;
        v_i = 1'b1; d_i = mk(1'b0, t);
        #1;
        while (now != t) begin
            if (rdy !== 1'b0 || pin !== 1'b1) held = 1'b0;
            @(negedge clk); #1;
        end
        check(held, "R5", "wait before due", 32'(held), 1);
        check(rdy == 1'b1, "R4", "ready at due", 32'(rdy), 1);
        check(pin == 1'b1, "R4", "pin before apply", 32'(pin), 1);
        @(negedge clk);
        v_i = 1'b0;
        #1;
        check(pin == 1'b0, "R1", "level bit applied", 32'(pin), 0);
        check(late == 1'b0, "R7", "on-time not late", 32'(late), 0);
    endtask

    task automatic t_same_time();
        logic [TW-1:0] t;
        @(negedge clk);
        t = now + 10;
        v_i = 1'b1; d_i = mk(1'b1, t);
        #1;
        while (now != t) begin @(negedge clk); #1; end
        check(rdy == 1'b1, "R8", "first same-time taken", 32'(rdy), 1);
        @(negedge clk);
        d_i = mk(1'b0, t);
        #1;
        check(pin == 1'b1, "R8", "first level", 32'(pin), 1);
        check(rdy == 1'b1, "R8", "follower taken next cycle", 32'(rdy), 1);
        @(negedge clk);
        v_i = 1'b0;
        #1;
        check(pin == 1'b0, "R8", "second level", 32'(pin), 0);
        check(late == 1'b0, "R8", "follower not late", 32'(late), 0);
    endtask

    task automatic t_hold();
        bit ok = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #1;
            if (pin !== 1'b0 || empty !== 1'b1 || rdy !== 1'b0) ok = 1'b0;
        end
        check(ok, "R9", "hold with no events", 32'(pin), 0);
    endtask

    task automatic t_late();
        bit ok = 1'b1;
        @(negedge clk);
        v_i = 1'b1; d_i = mk(1'b1, now - 5);
        #1;
        check(rdy == 1'b1, "R7", "overdue taken at once", 32'(rdy), 1);
        @(negedge clk);
        v_i = 1'b0;
        #1;
        check(pin == 1'b1, "R7", "overdue level", 32'(pin), 1);
        check(late == 1'b1, "R7", "late set", 32'(late), 1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1;
            if (late !== 1'b1) ok = 1'b0;
        end
        check(ok, "R7", "late sticky", 32'(late), 1);
    endtask

    task automatic t_wrap();
        bit held = 1'b1;
        bit wrapped = 1'b0;
        @(negedge clk); #1;
        while (now_n != 8'd250) begin @(negedge clk); #1; end
        vn_i = 1'b1; dn_i = {1'b1, 8'd4};
        #1;
        while (now_n != 8'd4) begin
            if (rdy_n !== 1'b0 || pin_n !== 1'b0) held = 1'b0;
            if (now_n == 8'd255) begin
                @(negedge clk); #1;
                check(now_n == 8'd0, "R3", "ref wraps to zero", 32'(now_n), 0);
                wrapped = 1'b1;
            end else begin
                @(negedge clk); #1;
            end
        end
        check(wrapped && held, "R6", "wait across wrap", {30'd0, wrapped, held}, 3);
        check(rdy_n == 1'b1, "R6", "taken after wrap", 32'(rdy_n), 1);
        @(negedge clk);
        dn_i = {1'b0, 8'd250};
        #1;
        check(pin_n == 1'b1 && late_n == 1'b0, "R6", "applied, not late",
              {30'd0, pin_n, late_n}, 2);
        check(rdy_n == 1'b1, "R6", "pre-wrap time is overdue", 32'(rdy_n), 1);
        @(negedge clk);
        vn_i = 1'b0;
        #1;
        check(pin_n == 1'b0 && late_n == 1'b1, "R7", "late across wrap",
              {30'd0, pin_n, late_n}, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_step();
        t_future();
        t_same_time();
        t_hold();
        t_late();
        t_wrap();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule